// File: doc/BRIEF.md
# Floating-point to 64-bit integer converter

This block turns a double-precision operand into a 64-bit integer. A 3-bit conversion mode picks the integer range. Modes 0 and 1 give a signed two's-complement result. Modes 2 to 7 give an unsigned result. Bit 2 of the mode also forces truncation. Otherwise a 2-bit rounding-mode input picks the rounding direction. Values that cannot be represented saturate and raise an invalid-conversion flag. The block keeps sticky status bits for signalling-NaN, invalid-conversion and inexact events, plus a summary bit.

Operands enter on a valid/ready stream and results leave on another one. The block holds an operand until `in_valid` and `in_ready` are both high at a clock edge. A result leaves when `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the whole pipeline stalls. `in_ready` is then low and the output result stays fixed. Results come out in order, two cycles after acceptance when nothing stalls.

When the invalid-exception enable is set and the operation is invalid, the destination write is suppressed. Each result also reports whether the fraction was rounded, whether it was inexact, and whether the integer, converted back exactly, differs from the source.

Top module: `f2i64_conv`

## Requirements
- R1: An operand is accepted at an edge where `in_valid` and `in_ready` are both high. `in_ready` is low exactly while `out_valid` is high and `out_ready` is low. A stalled output holds its value. Results appear in acceptance order.
- R2: The block rounds toward zero when `in_cvt_mode[2]` is 1 or `in_rnd_mode` is 01. Otherwise it uses rounding mode 00 for nearest-even, 10 toward +infinity and 11 toward -infinity.
- R3: Modes 0 and 1 give a signed two's-complement result in the range -2^63 to 2^63-1. Modes 2 to 7 give an unsigned result in the range 0 to 2^64-1. An in-range rounded value is output exactly.
- R4: A value whose rounded integer lies above the range, or +infinity, gives the range maximum. A value below the range, or -infinity, gives the range minimum. Both cases raise invalid-conversion, and the value is not reported as rounded or inexact.
- R5: A NaN gives the range minimum (0x8000_0000_0000_0000 signed, 0 unsigned) and raises invalid-conversion. A NaN whose top fraction bit (bit 51) is 0 is signalling and also raises the signalling-NaN flag.
- R6: For an in-range value, `out_frac_inexact` is 1 when discarded fraction bits were nonzero. `out_frac_rnd` is 1 when rounding increased the magnitude.
- R7: `out_overflow` is 1 when the source is a NaN, or when the integer result, converted back exactly, does not equal the source. Negative zero equals an integer 0.
- R8: When `in_inv_en` is 1 and signalling-NaN or invalid-conversion is raised, `out_write` is 0 and `out_frac_rnd`, `out_frac_inexact` and `out_overflow` are 0. `out_result` is then unspecified. `in_inv_en` has no effect on valid operations.
- R9: The sticky bits for signalling-NaN, invalid-conversion and inexact are set when a result that raises them enters the output register. Only reset clears them. `sticky_summary` is set whenever one of those bits goes newly from 0 to 1.
- R10: After reset, `out_valid` is 0, `in_ready` is 1, and all sticky bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand valid |
| in_ready | output | 1 | Operand can be accepted |
| in_operand | input | 64 | Double-precision source |
| in_cvt_mode | input | 3 | Range select; bit 2 forces truncation |
| in_rnd_mode | input | 2 | Rounding direction |
| in_inv_en | input | 1 | Invalid-exception enable |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes result |
| out_result | output | 64 | Integer result |
| out_write | output | 1 | Destination write enabled |
| out_frac_rnd | output | 1 | Magnitude was rounded up |
| out_frac_inexact | output | 1 | Result is inexact |
| out_overflow | output | 1 | Result differs from source |
| sticky_snan | output | 1 | Sticky signalling-NaN |
| sticky_cvi | output | 1 | Sticky invalid-conversion |
| sticky_inexact | output | 1 | Sticky inexact |
| sticky_summary | output | 1 | Sticky summary |

## Verification
The hardest cases to reach are operands that sit on a range edge only after rounding. Examples are -2^63, which is exactly representable when signed, and 2^63, which is exact only when unsigned. Negative fractions in unsigned mode are another: nearest rounding makes them -1 and invalid, while ceiling makes them 0 and merely inexact. The stimulus reaches these cases with hand-chosen encodings: powers of two at the exponent limits, the largest double below 2^64, and the smallest denormals of either sign. Each is sent under several mode and rounding pairings. The whole list is then replayed with random back-pressure, so that stalls fall on every kind of result.

// File: rtl/f2i64_pkg.sv
package f2i64_pkg;
  localparam int EXP_W = 11;
  localparam int MAN_W = 52;
  localparam int FP_W  = 1 + EXP_W + MAN_W;
  localparam int INT_W = 64;
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam int FX_W  = 2 * INT_W;
  localparam int LZ_W  = $clog2(INT_W) + 1;
  localparam int NFLAG = 3;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_UP   = 2'b10,
    RM_DOWN = 2'b11
  } rmode_e;

  typedef struct packed {
    logic [INT_W-1:0] value;
    logic             signed_mode;
    logic             nan;
    logic             snan;
    logic             cvi;
    logic             inexact;
    logic             incr;
    logic             inv_en;
    logic             src_sign;
    logic [EXP_W-1:0] src_exp;
    logic [MAN_W-1:0] src_man;
  } cvt_t;

  typedef struct packed {
    logic [INT_W-1:0] value;
    logic             write;
    logic             frac_rnd;
    logic             frac_inexact;
    logic             overflow;
  } res_t;
endpackage

// File: rtl/f2i64_round.sv
module f2i64_round
  import f2i64_pkg::*;
(
  input  logic [FP_W-1:0] operand,
  input  logic [2:0]      cvt_mode,
  input  logic [1:0]      rnd_mode,
  input  logic            inv_en,
  output cvt_t            cvt
);
  localparam int MID_LO = BIAS - 1;
  localparam int BIG_LO = BIAS + INT_W;
  localparam int SH_OFS = INT_W - MAN_W - BIAS;
  localparam logic [INT_W-1:0] SMIN = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [INT_W-1:0] SMAX = ~SMIN;
  localparam logic [INT_W-1:0] UMIN = '0;
  localparam logic [INT_W-1:0] UMAX = '1;

  logic             sgn;
  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] man;
  assign {sgn, ex, man} = operand;

  logic             is_nan, is_zero, is_big, is_mid, tiny_nz;
  logic             guard, sticky, lsb, inc, force_trunc;
  logic             signed_mode, fits, in_range;
  logic [FX_W-1:0]  fx;
  logic [INT_W-1:0] ipart, rmin, rmax, conv_val;
  logic [INT_W:0]   magr;

  always_comb begin
    is_nan  = (ex == '1) && (man != '0);
    is_zero = (ex == '0) && (man == '0);
    is_big  = int'(ex) >= BIG_LO;
    is_mid  = (int'(ex) >= MID_LO) && !is_big;
    tiny_nz = !is_mid && !is_big && !is_zero;

    // fixed point: INT_W integer bits over INT_W fraction bits
    fx = '0;
    if (is_mid)
      fx = {{(FX_W-MAN_W-1){1'b0}}, 1'b1, man} << (int'(ex) + SH_OFS);

    ipart  = fx[FX_W-1:INT_W];
    guard  = fx[INT_W-1];
    sticky = (|fx[INT_W-2:0]) | tiny_nz;
    lsb    = ipart[0];

    force_trunc = cvt_mode[2] || (rnd_mode == RM_ZERO);
    inc = 1'b0;
    if (!force_trunc) begin
      case (rmode_e'(rnd_mode))
        RM_NEAR: inc = guard & (sticky | lsb);
        RM_UP:   inc = !sgn & (guard | sticky);
        RM_DOWN: inc = sgn & (guard | sticky);
        default: inc = 1'b0;
      endcase
    end
    magr = {1'b0, ipart} + {{INT_W{1'b0}}, inc};

    signed_mode = (cvt_mode[2:1] == 2'b00);
    if (signed_mode) begin
      rmin = SMIN;
      rmax = SMAX;
      if (sgn) fits = !magr[INT_W] && (!magr[INT_W-1] || (magr[INT_W-2:0] == '0));
      else     fits = (magr[INT_W:INT_W-1] == 2'b00);
    end else begin
      rmin = UMIN;
      rmax = UMAX;
      if (sgn) fits = (magr == '0);
      else     fits = !magr[INT_W];
    end
    in_range = !is_nan && !is_big && fits;

    if (is_nan)         conv_val = rmin;
    else if (!in_range) conv_val = sgn ? rmin : rmax;
    else if (sgn)       conv_val = ~magr[INT_W-1:0] + 1'b1;
    else                conv_val = magr[INT_W-1:0];

    cvt.value       = conv_val;
    cvt.signed_mode = signed_mode;
    cvt.nan         = is_nan;
    cvt.snan        = is_nan && !man[MAN_W-1];
    cvt.cvi         = !in_range;
    cvt.inexact     = in_range && (guard || sticky);
    cvt.incr        = in_range && inc;
    cvt.inv_en      = inv_en;
    cvt.src_sign    = sgn;
    cvt.src_exp     = ex;
    cvt.src_man     = man;
  end
endmodule

// File: rtl/f2i64_backcmp.sv
module f2i64_backcmp
  import f2i64_pkg::*;
(
  input  cvt_t c,
  output logic equal
);
  localparam int EXP_TOP = BIAS + INT_W - 1;

  logic             rs, found, src_zero, src_norm, exp_ok, man_ok;
  logic [INT_W-1:0] mag, norm;
  logic [LZ_W-1:0]  lz;

  always_comb begin
    rs  = c.signed_mode & c.value[INT_W-1];
    mag = rs ? (~c.value + 1'b1) : c.value;

    lz    = LZ_W'(INT_W);
    found = 1'b0;
    for (int i = INT_W - 1; i >= 0; i--) begin
      if (!found && mag[i]) begin
        lz    = LZ_W'(INT_W - 1 - i);
        found = 1'b1;
      end
    end
    norm = mag << lz;

    src_zero = (c.src_exp == '0) && (c.src_man == '0);
    src_norm = (c.src_exp != '0) && (c.src_exp != '1);
    exp_ok   = int'(c.src_exp) == (EXP_TOP - int'(lz));
    man_ok   = norm == {1'b1, c.src_man, {(INT_W-MAN_W-1){1'b0}}};

    if (!found) equal = src_zero;
    else        equal = src_norm && (rs == c.src_sign) && exp_ok && man_ok;
  end
endmodule

// File: rtl/f2i64_sticky.sv
module f2i64_sticky #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd,
  input  logic [N-1:0] raise,
  output logic [N-1:0] flags,
  output logic         summary
);
  logic [N-1:0] fresh;

  for (genvar g = 0; g < N; g++) begin : g_flag
    assign fresh[g] = raise[g] & ~flags[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flags[g] <= 1'b0;
      else if (upd) flags[g] <= flags[g] | raise[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                summary <= 1'b0;
    else if (upd && |fresh)    summary <= 1'b1;
  end
endmodule

// File: rtl/f2i64_conv.sv
module f2i64_conv
  import f2i64_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [FP_W-1:0]  in_operand,
  input  logic [2:0]       in_cvt_mode,
  input  logic [1:0]       in_rnd_mode,
  input  logic             in_inv_en,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [INT_W-1:0] out_result,
  output logic             out_write,
  output logic             out_frac_rnd,
  output logic             out_frac_inexact,
  output logic             out_overflow,
  output logic             sticky_snan,
  output logic             sticky_cvi,
  output logic             sticky_inexact,
  output logic             sticky_summary
);
  cvt_t cvt_d, s1;
  res_t res_d, s2;
  logic s1_v, s2_v, adv, eq, vx, supp;
  logic [NFLAG-1:0] flags;

  assign adv      = !s2_v || out_ready;
  assign in_ready = adv;

  f2i64_round u_round (
    .operand  (in_operand),
    .cvt_mode (in_cvt_mode),
    .rnd_mode (in_rnd_mode),
    .inv_en   (in_inv_en),
    .cvt      (cvt_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   s1_v <= 1'b0;
    else if (adv) s1_v <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (adv && in_valid) s1 <= cvt_d;
  end

  f2i64_backcmp u_back (
    .c     (s1),
    .equal (eq)
  );

  always_comb begin
    vx   = s1.snan | s1.cvi;
    supp = s1.inv_en & vx;
    res_d.value        = s1.value;
    res_d.write        = !supp;
    res_d.frac_rnd     = !supp & s1.incr;
    res_d.frac_inexact = !supp & s1.inexact;
    res_d.overflow     = !supp & (s1.nan | !eq);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   s2_v <= 1'b0;
    else if (adv) s2_v <= s1_v;
  end

  always_ff @(posedge clk) begin
    if (adv && s1_v) s2 <= res_d;
  end

  f2i64_sticky #(.N(NFLAG)) u_sticky (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (adv && s1_v),
    .raise   ({s1.inexact, s1.cvi, s1.snan}),
    .flags   (flags),
    .summary (sticky_summary)
  );

  assign sticky_snan      = flags[0];
  assign sticky_cvi       = flags[1];
  assign sticky_inexact   = flags[2];
  assign out_valid        = s2_v;
  assign out_result       = s2.value;
  assign out_write        = s2.write;
  assign out_frac_rnd     = s2.frac_rnd;
  assign out_frac_inexact = s2.frac_inexact;
  assign out_overflow     = s2.overflow;
endmodule

// File: rtl/f2i64_conv_checker.sv
module f2i64_conv_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_result,
  input logic        out_write,
  input logic        out_frac_rnd,
  input logic        out_frac_inexact,
  input logic        out_overflow,
  input logic        sticky_snan,
  input logic        sticky_cvi,
  input logic        sticky_inexact,
  input logic        sticky_summary
);
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_write)
                                   && $stable(out_overflow)));

  assert_rnd_needs_inexact_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_frac_rnd) |-> out_frac_inexact);

  assert_inexact_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_frac_inexact) |-> out_overflow);

  assert_quiet_suppressed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_write) |-> (!out_frac_rnd && !out_frac_inexact && !out_overflow));

  assert_sticky_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_snan || sticky_cvi || sticky_inexact || sticky_summary) |=>
      ((sticky_snan >= $past(sticky_snan)) && (sticky_cvi >= $past(sticky_cvi)) &&
       (sticky_inexact >= $past(sticky_inexact)) && (sticky_summary >= $past(sticky_summary))));

  assert_summary_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sticky_snan) || $rose(sticky_cvi) || $rose(sticky_inexact)) |-> sticky_summary);
endmodule

bind f2i64_conv f2i64_conv_checker u_checker (
  .clk              (clk),
  .rst_n            (rst_n),
  .out_valid        (out_valid),
  .out_ready        (out_ready),
  .out_result       (out_result),
  .out_write        (out_write),
  .out_frac_rnd     (out_frac_rnd),
  .out_frac_inexact (out_frac_inexact),
  .out_overflow     (out_overflow),
  .sticky_snan      (sticky_snan),
  .sticky_cvi       (sticky_cvi),
  .sticky_inexact   (sticky_inexact),
  .sticky_summary   (sticky_summary)
);

// File: tb/f2i64_conv_bench.sv
`timescale 1ns/1ps
module f2i64_conv_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_operand = '0;
  logic [2:0]  in_cvt_mode = '0;
  logic [1:0]  in_rnd_mode = '0;
  logic        in_inv_en = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;
  logic        out_write, out_frac_rnd, out_frac_inexact, out_overflow;
  logic        sticky_snan, sticky_cvi, sticky_inexact, sticky_summary;

  always #2 clk = ~clk;

  f2i64_conv u_f2i64_conv (.*);

  typedef struct packed {
    logic [63:0] val;
    logic wr, fr, fi, ov, sn, cv;
  } exp_t;

  exp_t  q[$];
  string tq[$];
  int    checks = 0;
  int    failures = 0;
  logic  stall_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic  m_sn = 0, m_cv = 0, m_xx = 0;
  logic  hold_pending = 0;
  logic [63:0] held;
  logic  done = 0;

  task automatic chk(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready <= stall_mode ? lfsr[3] : 1'b1;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pending) begin
        chk("R1", "stall keeps valid", {63'b0, out_valid}, 64'd1);
        chk("R1", "stall keeps result", out_result, held);
        hold_pending = 0;
      end
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          chk("R1", "unexpected result", out_result, 64'hx);
        end else begin
          exp_t e;
          string t;
          e = q.pop_front();
          t = tq.pop_front();
          chk(t, "write", {63'b0, out_write}, {63'b0, e.wr});
          if (e.wr) chk(t, "result", out_result, e.val);
          chk(t, "frac_rnd", {63'b0, out_frac_rnd}, {63'b0, e.fr});
          chk(t, "frac_inexact", {63'b0, out_frac_inexact}, {63'b0, e.fi});
          chk(t, "overflow", {63'b0, out_overflow}, {63'b0, e.ov});
          m_sn = m_sn | e.sn;
          m_cv = m_cv | e.cv;
          m_xx = m_xx | e.fi;
          chk("R9", "sticky snan", {63'b0, sticky_snan}, {63'b0, m_sn});
          chk("R9", "sticky cvi", {63'b0, sticky_cvi}, {63'b0, m_cv});
          chk("R9", "sticky inexact", {63'b0, sticky_inexact}, {63'b0, m_xx});
          chk("R9", "sticky summary", {63'b0, sticky_summary}, {63'b0, m_sn | m_cv | m_xx});
        end
      end else if (out_valid && !out_ready) begin
        hold_pending = 1;
        held = out_result;
        chk("R1", "in_ready low in stall", {63'b0, in_ready}, 64'd0);
      end
    end
  end

  task automatic send(input logic [63:0] op, input logic [2:0] mode, input logic [1:0] rnd,
                      input logic inv, input logic [63:0] val, input logic wr, input logic fr,
                      input logic fi, input logic ov, input logic sn, input logic cv,
                      input string tag);
    exp_t e;
    @(negedge clk);
    if (stall_mode && lfsr[5]) begin
      in_valid = 1'b0;
      @(negedge clk);
    end
    in_valid = 1'b1;
    in_operand = op;
    in_cvt_mode = mode;
    in_rnd_mode = rnd;
    in_inv_en = inv;
    while (!in_ready) @(negedge clk);
    e = '{val: val, wr: wr, fr: fr, fi: fi, ov: ov, sn: sn, cv: cv};
    q.push_back(e);
    tq.push_back(tag);
  endtask

  localparam logic [63:0] SMIN = 64'h8000_0000_0000_0000;
  localparam logic [63:0] SMAX = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  task automatic run_list();
    // R2: rounding selection
    send(64'h3FF0_0000_0000_0000, 3'd0, 2'b00, 0, 64'd1, 1, 0, 0, 0, 0, 0, "R2");
    send(64'h3FF8_0000_0000_0000, 3'd0, 2'b00, 0, 64'd2, 1, 1, 1, 1, 0, 0, "R2");
    send(64'h4004_0000_0000_0000, 3'd0, 2'b00, 0, 64'd2, 1, 0, 1, 1, 0, 0, "R2");
    send(64'hC004_0000_0000_0000, 3'd1, 2'b00, 0, 64'hFFFF_FFFF_FFFF_FFFE, 1, 0, 1, 1, 0, 0, "R2");
    send(64'h4004_0000_0000_0000, 3'd0, 2'b10, 0, 64'd3, 1, 1, 1, 1, 0, 0, "R2");
    send(64'hC004_0000_0000_0000, 3'd0, 2'b10, 0, 64'hFFFF_FFFF_FFFF_FFFE, 1, 0, 1, 1, 0, 0, "R2");
    send(64'hC004_0000_0000_0000, 3'd0, 2'b11, 0, 64'hFFFF_FFFF_FFFF_FFFD, 1, 1, 1, 1, 0, 0, "R2");
    send(64'h4004_0000_0000_0000, 3'd0, 2'b01, 0, 64'd2, 1, 0, 1, 1, 0, 0, "R2");
    send(64'h4004_0000_0000_0000, 3'd4, 2'b10, 0, 64'd2, 1, 0, 1, 1, 0, 0, "R2");
    // R7 / R3: exact and boundary values
    send(64'h8000_0000_0000_0000, 3'd0, 2'b00, 0, 64'd0, 1, 0, 0, 0, 0, 0, "R7");
    send(64'hC3E0_0000_0000_0000, 3'd0, 2'b00, 0, SMIN, 1, 0, 0, 0, 0, 0, "R3");
    send(64'h43E0_0000_0000_0000, 3'd0, 2'b00, 0, SMAX, 1, 0, 0, 1, 0, 1, "R4");
    send(64'h43E0_0000_0000_0000, 3'd2, 2'b00, 0, SMIN, 1, 0, 0, 0, 0, 0, "R3");
    send(64'h43EF_FFFF_FFFF_FFFF, 3'd3, 2'b00, 0, 64'hFFFF_FFFF_FFFF_F800, 1, 0, 0, 0, 0, 0, "R3");
    send(64'h43F0_0000_0000_0000, 3'd2, 2'b00, 0, ONES, 1, 0, 0, 1, 0, 1, "R4");
    send(64'hBFF8_0000_0000_0000, 3'd2, 2'b01, 0, 64'd0, 1, 0, 0, 1, 0, 1, "R4");
    send(64'hBFE8_0000_0000_0000, 3'd2, 2'b10, 0, 64'd0, 1, 0, 1, 1, 0, 0, "R3");
    send(64'h7FF0_0000_0000_0000, 3'd6, 2'b00, 0, ONES, 1, 0, 0, 1, 0, 1, "R4");
    send(64'hFFF0_0000_0000_0000, 3'd0, 2'b00, 0, SMIN, 1, 0, 0, 1, 0, 1, "R4");
    // R5: NaNs
    send(64'h7FF8_0000_0000_0000, 3'd0, 2'b00, 0, SMIN, 1, 0, 0, 1, 0, 1, "R5");
    send(64'h7FF8_0000_0000_0000, 3'd5, 2'b00, 0, 64'd0, 1, 0, 0, 1, 0, 1, "R5");
    // R6: denormals
    send(64'h0000_0000_0000_0001, 3'd0, 2'b10, 0, 64'd1, 1, 1, 1, 1, 0, 0, "R6");
    send(64'h8000_0000_0000_0001, 3'd1, 2'b11, 0, ONES, 1, 1, 1, 1, 0, 0, "R6");
    send(64'h0000_0000_0000_0001, 3'd0, 2'b00, 0, 64'd0, 1, 0, 1, 1, 0, 0, "R6");
    // R8: suppression
    send(64'h43E0_0000_0000_0000, 3'd0, 2'b00, 1, 64'd0, 0, 0, 0, 0, 0, 1, "R8");
    send(64'hBFF8_0000_0000_0000, 3'd1, 2'b00, 1, 64'hFFFF_FFFF_FFFF_FFFE, 1, 1, 1, 1, 0, 0, "R8");
    send(64'h7FF0_0000_0000_0001, 3'd0, 2'b00, 1, 64'd0, 0, 0, 0, 0, 1, 1, "R8");
    send(64'h7FF0_0000_0000_0001, 3'd0, 2'b00, 0, SMIN, 1, 0, 0, 1, 1, 1, "R5");
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "out_valid after reset", {63'b0, out_valid}, 64'd0);
    chk("R10", "in_ready after reset", {63'b0, in_ready}, 64'd1);
    chk("R10", "stickies after reset",
        {60'b0, sticky_snan, sticky_cvi, sticky_inexact, sticky_summary}, 64'd0);
    run_list();
    wait (q.size() == 0);
    repeat (4) @(negedge clk);
    stall_mode = 1'b1;
    run_list();
    run_list();
    wait (q.size() == 0);
    repeat (6) @(negedge clk);
    chk("R1", "all results drained", {63'b0, out_valid}, 64'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule